// File: doc/BRIEF.md
# Tagged Line Burst Memory Responder

This block is a memory slave for a cache that moves whole lines. A requester issues commands on one valid/ready channel: each command carries a write flag, a line address and a tag. A write command opens a store, and the line's words then arrive one per beat on a separate write-data channel. A read command is answered on a response channel that has no ready. Each line comes back as a burst of one word per cycle, and every beat of the burst repeats the request tag.

Storage is an on-chip synchronous RAM of `MEM_WORDS` words. It is split into `LINE_WORDS` banks, one per word offset, so a read fetches a whole line in one cycle. The line is then pushed into a response queue in one step. The queue shows its head entry whenever it is not empty and drops that entry at the next clock edge.

Top module: `line_mem_responder`

## Requirements
- R1: After reset, `cmd_ready` is 1, `wdat_ready` is 0 and `rsp_valid` is 0.
- R2: `cmd_ready` and `wdat_ready` are always complements. A command accepted with `cmd_write`=1 (0 means read) switches the block to the data phase from the next cycle: `cmd_ready`=0 and `wdat_ready`=1.
- R3: During the data phase, accepted beat number k (counted from 0) writes word offset k of the latched line. After `LINE_WORDS` beats the block leaves the data phase, and `cmd_ready` returns to 1.
- R4: Line address a covers memory words a*`LINE_WORDS` to a*`LINE_WORDS`+`LINE_WORDS`-1. A store to one line leaves every other line unchanged.
- R5: A read accepted at clock edge E produces nothing after E. `LINE_WORDS` beats follow after edges E+1 to E+`LINE_WORDS`, with word offsets in ascending order from 0. Every beat carries the command's tag.
- R6: The response channel has no ready. Each beat is shown for exactly one cycle, and bursts from back-to-back reads follow each other with no gap, in command order.
- R7: While the response queue is empty, `rsp_tag` is 0 and `rsp_data` equals the parameter `IDLE_WORD`.
- R8: Input on a channel whose ready is low has no effect. Write data offered outside the data phase changes no memory word. A command offered during the data phase yields no response.
- R9: The response queue holds `MAX_READS`*`LINE_WORDS` beats. Issuing reads faster than the queue can hold them breaks the usage contract and is flagged by an assertion.
- R10: Valid line addresses run from 0 to `MEM_WORDS`/`LINE_WORDS`-1, and the highest line stores and reads back like any other. An accepted command with a higher line address is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle if valid |
| cmd_write | input | 1 | 1 = store line, 0 = read line |
| cmd_line | input | ADDR_W | Line address |
| cmd_tag | input | TAG_W | Request tag |
| wdat_valid | input | 1 | Write word offered |
| wdat_ready | output | 1 | Store in flight, write word accepted if valid |
| wdat_word | input | WORD_W | Write word |
| rsp_valid | output | 1 | Response beat present |
| rsp_tag | output | TAG_W | Tag of the response beat, 0 when idle |
| rsp_data | output | WORD_W | Response word, `IDLE_WORD` when idle |

## Verification
The bench uses the default parameters: 4-word lines, 32-bit words, 4-bit tags, 64 words of storage (16 lines) and a queue sized for two reads. With only 16 lines, the lowest and the highest line can both be exercised, and several distinct lines can be written and then read again to show that they do not interfere. The queue depth of eight beats allows two reads issued back to back, so the hand-off between two bursts with no gap can be observed. A third back-to-back read would exceed the queue, and the bench does not issue one.

// File: rtl/lmr_pkg.sv
package lmr_pkg;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_STORE = 1'b1
    } lmr_op_e;

    function automatic int wrap_add(input int a, input int b, input int m);
        return (a + b) % m;
    endfunction

endpackage

// File: rtl/lmr_bank.sv
module lmr_bank #(
    parameter int WORD_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem_q [LINES];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/lmr_store_seq.sv
module lmr_store_seq #(
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 16,
    localparam int BEAT_W    = $clog2(LINE_WORDS),
    localparam int IDX_W     = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_line,
    input  logic              beat,
    output logic              in_flight,
    output logic [BEAT_W-1:0] beat_idx,
    output logic [IDX_W-1:0]  base_line
);
    typedef struct packed {
        logic              busy;
        logic [BEAT_W-1:0] cnt;
        logic [IDX_W-1:0]  base;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (start) begin
            seq_d.busy = 1'b1;
            seq_d.base = start_line;
            seq_d.cnt  = '0;
        end
        if (beat) begin
            if (int'(seq_q.cnt) == LINE_WORDS - 1) begin
                seq_d.cnt  = '0;
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign in_flight = seq_q.busy;
    assign beat_idx  = seq_q.cnt;
    assign base_line = seq_q.base;

    // R2: a store command opens the data phase at word 0
    assert_store_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (in_flight && beat_idx == '0));

    // R3: the last beat of a line closes the data phase
    assert_store_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && int'(beat_idx) == LINE_WORDS - 1) |=> !in_flight);
endmodule

// File: rtl/lmr_resp_queue.sv
module lmr_resp_queue #(
    parameter int WORD_W     = 32,
    parameter int TAG_W      = 4,
    parameter int LINE_WORDS = 4,
    parameter int DEPTH      = 8,
    parameter logic [WORD_W-1:0] IDLE_WORD = '0,
    localparam int PTR_W     = $clog2(DEPTH),
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_line,
    input  logic [TAG_W-1:0]             push_tag,
    input  logic [LINE_WORDS*WORD_W-1:0] push_words,
    output logic                         head_valid,
    output logic [TAG_W-1:0]             head_tag,
    output logic [WORD_W-1:0]            head_data
);
    import lmr_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0][TAG_W-1:0]  tag;
        logic [DEPTH-1:0][WORD_W-1:0] data;
        logic [PTR_W-1:0]             wr;
        logic [PTR_W-1:0]             rd;
        logic [CNT_W-1:0]             cnt;
    } q_t;

    q_t q_d, q_q;
    logic pop;

    assign pop = (q_q.cnt != '0);

    always_comb begin
        logic [PTR_W-1:0] slot;
        q_d = q_q;
        slot = '0;
        if (pop) q_d.rd = PTR_W'(wrap_add(int'(q_q.rd), 1, DEPTH));
        if (push_line) begin
            for (int i = 0; i < LINE_WORDS; i++) begin
                slot = PTR_W'(wrap_add(int'(q_q.wr), i, DEPTH));
                q_d.tag[slot]  = push_tag;
                q_d.data[slot] = push_words[i*WORD_W +: WORD_W];
            end
            q_d.wr = PTR_W'(wrap_add(int'(q_q.wr), LINE_WORDS, DEPTH));
        end
        q_d.cnt = CNT_W'(int'(q_q.cnt) + (push_line ? LINE_WORDS : 0) - (pop ? 1 : 0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_valid = pop;
    assign head_tag   = pop ? q_q.tag[q_q.rd]  : '0;
    assign head_data  = pop ? q_q.data[q_q.rd] : IDLE_WORD;

    // R9: a pushed line must fit next to what remains after this cycle's pop
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        push_line |-> (int'(q_q.cnt) - (pop ? 1 : 0) + LINE_WORDS <= DEPTH));

    // R6: with no new line, each shown beat is retired at the next edge
    assert_beat_retired_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push_line) |=> (q_q.cnt == CNT_W'($past(q_q.cnt) - 1'b1)));
endmodule

// File: rtl/line_mem_responder.sv
module line_mem_responder #(
    parameter int WORD_W     = 32,
    parameter int TAG_W      = 4,
    parameter int LINE_WORDS = 4,
    parameter int MEM_WORDS  = 64,
    parameter int ADDR_W     = 6,
    parameter int MAX_READS  = 2,
    parameter logic [WORD_W-1:0] IDLE_WORD = 32'hA5A5_5A5A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_line,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic              wdat_valid,
    output logic              wdat_ready,
    input  logic [WORD_W-1:0] wdat_word,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic [WORD_W-1:0] rsp_data
);
    import lmr_pkg::*;

    localparam int LINES  = MEM_WORDS / LINE_WORDS;
    localparam int IDX_W  = $clog2(LINES);
    localparam int BEAT_W = $clog2(LINE_WORDS);
    localparam int QDEPTH = MAX_READS * LINE_WORDS;

    typedef struct packed {
        logic             pend;
        logic [TAG_W-1:0] tag;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              in_flight;
    logic [BEAT_W-1:0] beat_idx;
    logic [IDX_W-1:0]  base_line;
    logic              cmd_fire, rd_fire, st_fire, dat_fire;
    logic [IDX_W-1:0]  line_idx;
    logic [WORD_W-1:0] bank_rd [LINE_WORDS];
    logic [LINE_WORDS*WORD_W-1:0] line_flat;

    assign cmd_ready  = !in_flight;
    assign wdat_ready = in_flight;
    assign cmd_fire   = cmd_valid && cmd_ready;
    assign rd_fire    = cmd_fire && (lmr_op_e'(cmd_write) == OP_READ);
    assign st_fire    = cmd_fire && (lmr_op_e'(cmd_write) == OP_STORE);
    assign dat_fire   = wdat_valid && wdat_ready;
    assign line_idx   = cmd_line[IDX_W-1:0];

    lmr_store_seq #(
        .LINE_WORDS(LINE_WORDS),
        .LINES     (LINES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (st_fire),
        .start_line(line_idx),
        .beat      (dat_fire),
        .in_flight (in_flight),
        .beat_idx  (beat_idx),
        .base_line (base_line)
    );

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_bank
        lmr_bank #(
            .WORD_W(WORD_W),
            .LINES (LINES)
        ) u_bank (
            .clk  (clk),
            .we   (dat_fire && (beat_idx == BEAT_W'(g))),
            .waddr(base_line),
            .wdata(wdat_word),
            .re   (rd_fire),
            .raddr(line_idx),
            .rdata(bank_rd[g])
        );
    end

    always_comb begin
        for (int i = 0; i < LINE_WORDS; i++)
            line_flat[i*WORD_W +: WORD_W] = bank_rd[i];
    end

    always_comb begin
        rd_d      = rd_q;
        rd_d.pend = rd_fire;
        if (rd_fire) rd_d.tag = cmd_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    lmr_resp_queue #(
        .WORD_W    (WORD_W),
        .TAG_W     (TAG_W),
        .LINE_WORDS(LINE_WORDS),
        .DEPTH     (QDEPTH),
        .IDLE_WORD (IDLE_WORD)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_line (rd_q.pend),
        .push_tag  (rd_q.tag),
        .push_words(line_flat),
        .head_valid(rsp_valid),
        .head_tag  (rsp_tag),
        .head_data (rsp_data)
    );

    // R10: accepted commands must address an existing line
    assert_line_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |-> (int'(cmd_line) < LINES));

    // R5: a read shows no beat after its acceptance edge unless one was already queued
    assert_read_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !rsp_valid && !rd_q.pend) |=> !rsp_valid);
endmodule

// File: tb/sim_line_mem_responder.sv
`timescale 1ns/1ps
module sim_line_mem_responder;
    localparam int W = 32;
    localparam int T = 4;
    localparam int L = 4;
    localparam int A = 6;
    localparam logic [W-1:0] IDLE = 32'hA5A5_5A5A;
    localparam int NV = 4;
    localparam logic [A-1:0] V_LINE [NV] = '{6'd0, 6'd5, 6'd15, 6'd9};
    localparam logic [T-1:0] V_TAG  [NV] = '{4'd3, 4'd7, 4'd15, 4'd1};
    localparam logic [W-1:0] V_BASE [NV] = '{32'h1000_0000, 32'h2222_0100, 32'hFFFF_FFF0, 32'h0BAD_0000};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_write = 1'b0, wdat_valid = 1'b0;
    logic [A-1:0] cmd_line = '0;
    logic [T-1:0] cmd_tag = '0;
    logic [W-1:0] wdat_word = '0;
    logic cmd_ready, wdat_ready, rsp_valid;
    logic [T-1:0] rsp_tag;
    logic [W-1:0] rsp_data;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    line_mem_responder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_write(cmd_write), .cmd_line(cmd_line), .cmd_tag(cmd_tag),
        .wdat_valid(wdat_valid), .wdat_ready(wdat_ready), .wdat_word(wdat_word),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic store_line(input logic [A-1:0] ln, input logic [W-1:0] base);
        cmd_valid = 1; cmd_write = 1; cmd_line = ln;
        step();
        cmd_valid = 0;
        chk(wdat_ready && !cmd_ready, "R2", "data phase after store command",
            {30'd0, cmd_ready, wdat_ready}, 32'd1);
        for (int i = 0; i < L; i++) begin
            wdat_valid = 1; wdat_word = base + W'(i);
            step();
        end
        wdat_valid = 0;
        chk(cmd_ready && !wdat_ready, "R3", "store closes after line beats",
            {30'd0, cmd_ready, wdat_ready}, 32'd2);
    endtask

    task automatic read_line(input logic [A-1:0] ln, input logic [T-1:0] tg,
                             input logic [W-1:0] base, input string req);
        cmd_valid = 1; cmd_write = 0; cmd_line = ln; cmd_tag = tg;
        step();
        cmd_valid = 0;
        chk(!rsp_valid, "R5", "no beat right after acceptance", {31'd0, rsp_valid}, 32'd0);
        for (int i = 0; i < L; i++) begin
            step();
            chk(rsp_valid && rsp_tag == tg, "R5", "beat valid with tag",
                {27'd0, rsp_valid, rsp_tag}, {27'd1, tg});
            chk(rsp_data == base + W'(i), req, "beat word", rsp_data, base + W'(i));
        end
        step();
        chk(!rsp_valid, "R6", "burst ends after line beats", {31'd0, rsp_valid}, 32'd0);
        chk(rsp_tag == '0 && rsp_data == IDLE, "R7", "idle data", rsp_data, IDLE);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1;
        // R1 reset state
        chk(cmd_ready && !wdat_ready && !rsp_valid, "R1", "reset state",
            {29'd0, cmd_ready, wdat_ready, rsp_valid}, 32'd4);
        chk(rsp_tag == '0 && rsp_data == IDLE, "R7", "idle after reset", rsp_data, IDLE);

        // table walk: store then read each line (R3, R5, R10 for line 15)
        for (int v = 0; v < NV; v++) begin
            store_line(V_LINE[v], V_BASE[v]);
            read_line(V_LINE[v], V_TAG[v], V_BASE[v], (V_LINE[v] == 15) ? "R10" : "R3");
        end
        // R4: every line still holds its own words
        for (int v = 0; v < NV; v++)
            read_line(V_LINE[v], 4'(v + 8), V_BASE[v], "R4");

        // R8: write data outside data phase is ignored
        wdat_valid = 1; wdat_word = 32'hDEAD_DEAD;
        chk(!wdat_ready, "R8", "no data ready when idle", {31'd0, wdat_ready}, 32'd0);
        step(); step();
        wdat_valid = 0;
        read_line(6'd5, 4'd2, V_BASE[1], "R8");

        // R8: a read offered during the data phase is not taken
        cmd_valid = 1; cmd_write = 1; cmd_line = 6'd3;
        step();
        cmd_write = 0; cmd_tag = 4'd6; cmd_line = 6'd0;
        for (int i = 0; i < L; i++) begin
            wdat_valid = 1; wdat_word = 32'h3300_0000 + W'(i);
            step();
            chk(!rsp_valid, "R8", "no response to blocked command", {31'd0, rsp_valid}, 32'd0);
        end
        cmd_valid = 0; wdat_valid = 0;
        step(); step();
        chk(!rsp_valid, "R8", "blocked command left no burst", {31'd0, rsp_valid}, 32'd0);
        read_line(6'd3, 4'd4, 32'h3300_0000, "R3");

        // R9/R6: two back-to-back reads fill the queue and drain without gap
        cmd_valid = 1; cmd_write = 0; cmd_line = 6'd0; cmd_tag = 4'd1;
        step();
        cmd_line = 6'd15; cmd_tag = 4'd2;
        step();
        cmd_valid = 0;
        for (int k = 0; k < 2 * L; k++) begin
            logic [W-1:0] e;
            logic [T-1:0] et;
            e  = (k < L) ? V_BASE[0] + W'(k) : V_BASE[2] + W'(k - L);
            et = (k < L) ? 4'd1 : 4'd2;
            chk(rsp_valid && rsp_tag == et, "R9", "back-to-back beat tag",
                {27'd0, rsp_valid, rsp_tag}, {27'd1, et});
            chk(rsp_data == e, "R6", "back-to-back beat word", rsp_data, e);
            step();
        end
        chk(!rsp_valid && rsp_data == IDLE, "R7", "idle after two bursts", rsp_data, IDLE);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule